// File: doc/BRIEF.md
# Hot-Plug Command Executor

This block takes 16-bit command words from a register write port and turns them into actions on a set of hot-plug slots. It also turns them into settings for the secondary bus. A command carries an 8-bit code in its low byte and a 1-based slot number in its high byte. A slot number of 0 is used for commands that act on the whole bus. Slot operations are bit-packed, so one code can change a slot's power/enable state, its power indicator and its attention indicator together. A 2-bit field value of zero leaves that item as it is. Bus-wide codes put every slot into power-only or enabled state, or select the bus speed/mode.

Each accepted command holds the busy flag for a fixed, parameterised number of cycles and then takes effect. At that point the command's error code is written to the status word, and a command-done flag is raised in the interrupt control word. The done flag requests an interrupt unless either of two mask bits is set. Software clears it by writing 1 to its bit position.

Top module: `hpcmd_exec`

## Requirements
- R1: After reset every slot reads state 3 (disabled), power indicator 3 (off) and attention indicator 3 (off). The bus mode reads 0 and the status word reads 0. The interrupt control word reads 0x5: global mask (bit 0) and command mask (bit 2) set, done flag (bit 16) clear. The interrupt request is low.
- R2: A command write made while not busy is accepted. Status bit 0 (busy) then reads 1 for exactly EXEC_CYCLES cycles, and the command takes effect when busy falls. The code is cmdWord[7:0] and the slot number is cmdWord[15:8].
- R3: Codes 00h–3Fh are slot operations. Bits [1:0] set the slot state (1 power-only, 2 enabled, 3 disabled). Bits [3:2] set the power indicator and bits [5:4] set the attention indicator (1 on, 2 blink, 3 off). A field value of 0 leaves that item unchanged. Slot n occupies bits [2n-1:2n-2] of slotState, pwrInd and attnInd.
- R4: A slot operation with slot number 0, or with a slot number above NUM_SLOTS, ends with the invalid-command error (status bits [3:1] = 3'b010) and changes no slot.
- R5: A slot operation with a nonzero state field, aimed at a slot whose MRL-open input is high when the command is accepted, ends with the switch-open error (status bits [3:1] = 3'b001) and changes nothing. An operation with a zero state field that only sets indicators still executes on such a slot.
- R6: Codes 40h–44h set busMode to code[2:0]. Codes 45h–47h end with the invalid-mode error (status bits [3:1] = 3'b100) and leave the mode unchanged.
- R7: Code 48h sets every slot whose MRL is closed to power-only (1), and code 49h sets every such slot to enabled (2). Slots with an open MRL are left as they are, and neither code reports an error.
- R8: Codes 50h–5Dh set busMode to code[3:0] only when progIf equals 2. With any other progIf value, and for codes 5Eh–5Fh, they end with the invalid-mode error.
- R9: Codes 4Ah–4Fh and 60h–FFh end with the invalid-command error and change no slot and no mode.
- R10: A command written while busy is ignored. The busy period, the error field and every slot and mode output keep the behaviour of the command already running.
- R11: Completion sets the done flag (bit 16). A write with bit 16 set clears the flag. If the clear arrives in the completion cycle, the flag still ends up set.
- R12: irqReq is high exactly when the done flag is set and both mask bits (0 and 2) are clear. Writes to the interrupt control word load bits 0 and 2.
- R13: Acceptance of a command clears the error field. The field is always one-hot or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command word write strobe |
| cmdWord | input | 16 | Command: slot number [15:8], code [7:0] |
| progIf | input | 8 | Programming-interface value; 2 allows the extended modes |
| mrlOpen | input | NUM_SLOTS | Per-slot MRL sensor, 1 = open |
| intWrEn | input | 1 | Interrupt control word write strobe |
| intWrData | input | 32 | Write data: masks at bits 0 and 2, clear-done at bit 16 |
| statusWord | output | 16 | Busy at bit 0, one-hot error code at bits [3:1] |
| intCtlWord | output | 32 | Masks at bits 0 and 2, done flag at bit 16 |
| irqReq | output | 1 | Interrupt request |
| slotState | output | 2*NUM_SLOTS | Per-slot power/enable state |
| pwrInd | output | 2*NUM_SLOTS | Per-slot power indicator |
| attnInd | output | 2*NUM_SLOTS | Per-slot attention indicator |
| busMode | output | 4 | Selected bus speed/mode |

## Verification
Two events can fall on the same clock edge. The first pair is the completion that sets the done flag and a software write that clears it. The bench drives that clear in the last busy cycle and expects the flag still set afterwards. The second pair is a new command write and the final busy cycle of the previous command. The bench issues a deliberately invalid command on that cycle, and also in the middle of a busy period. It then expects the busy length, the error field and every slot output to match the first command alone.

// File: rtl/hpcmd_pkg.sv
package hpcmd_pkg;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'b000,
    ERR_SWITCH  = 3'b001,
    ERR_BADCMD  = 3'b010,
    ERR_BADMODE = 3'b100
  } hpErr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic complete;
  } hpStrobe_t;

  // decoded action held while the command executes
  typedef struct packed {
    hpErr_t     err;
    logic       slotOp;
    logic [7:0] slotNum;
    logic [1:0] stFld;
    logic [1:0] pwrFld;
    logic [1:0] attnFld;
    logic       modeOp;
    logic [3:0] modeVal;
    logic       allOp;
    logic [1:0] allState;
  } hpAction_t;

  localparam logic [7:0] CODE_MODE_A_LO  = 8'h40;
  localparam logic [7:0] CODE_MODE_A_HI  = 8'h44;
  localparam logic [7:0] CODE_MODE_A_RSV = 8'h47;
  localparam logic [7:0] CODE_ALL_PWR    = 8'h48;
  localparam logic [7:0] CODE_ALL_EN     = 8'h49;
  localparam logic [7:0] CODE_MODE_B_LO  = 8'h50;
  localparam logic [7:0] CODE_MODE_B_HI  = 8'h5D;
  localparam logic [7:0] CODE_MODE_B_RSV = 8'h5F;
  localparam logic [7:0] EXT_PROG_IF     = 8'd2;

  localparam logic [1:0] ST_PWRONLY  = 2'd1;
  localparam logic [1:0] ST_ENABLED  = 2'd2;
  localparam logic [1:0] ST_DISABLED = 2'd3;
  localparam logic [1:0] IND_OFF     = 2'd3;

endpackage

// File: rtl/hpcmd_decode.sv
module hpcmd_decode
  import hpcmd_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic [15:0]          cmdWord,
  input  logic [7:0]           progIf,
  input  logic [NUM_SLOTS-1:0] mrlOpen,
  output hpAction_t            act
);

  localparam logic [7:0] MAX_SLOT = 8'(NUM_SLOTS);

  logic [7:0] code;
  logic [7:0] slotNum;
  logic       slotOk;
  logic       slotMrl;

  assign code    = cmdWord[7:0];
  assign slotNum = cmdWord[15:8];
  assign slotOk  = (slotNum != 8'd0) && (slotNum <= MAX_SLOT);

  always_comb begin
    slotMrl = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slotNum == 8'(i + 1)) slotMrl = mrlOpen[i];
    end
  end

  always_comb begin
    act = '0;
    if (code < CODE_MODE_A_LO) begin
      if (!slotOk) begin
        act.err = ERR_BADCMD;
      end else if (slotMrl && (code[1:0] != 2'd0)) begin
        act.err = ERR_SWITCH;
      end else begin
        act.slotOp  = 1'b1;
        act.slotNum = slotNum;
        act.stFld   = code[1:0];
        act.pwrFld  = code[3:2];
        act.attnFld = code[5:4];
      end
    end else if (code <= CODE_MODE_A_HI) begin
      act.modeOp  = 1'b1;
      act.modeVal = {1'b0, code[2:0]};
    end else if (code <= CODE_MODE_A_RSV) begin
      act.err = ERR_BADMODE;
    end else if (code == CODE_ALL_PWR) begin
      act.allOp    = 1'b1;
      act.allState = ST_PWRONLY;
    end else if (code == CODE_ALL_EN) begin
      act.allOp    = 1'b1;
      act.allState = ST_ENABLED;
    end else if (code < CODE_MODE_B_LO) begin
      act.err = ERR_BADCMD;
    end else if (code <= CODE_MODE_B_HI) begin
      if (progIf == EXT_PROG_IF) begin
        act.modeOp  = 1'b1;
        act.modeVal = code[3:0];
      end else begin
        act.err = ERR_BADMODE;
      end
    end else if (code <= CODE_MODE_B_RSV) begin
      act.err = ERR_BADMODE;
    end else begin
      act.err = ERR_BADCMD;
    end
  end

endmodule

// File: rtl/hpcmd_ctrl.sv
module hpcmd_ctrl
  import hpcmd_pkg::*;
#(
  parameter int EXEC_CYCLES = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic        intWrEn,
  input  logic [31:0] intWrData,
  output hpStrobe_t   strb,
  output logic        busy,
  output logic [31:0] intCtlWord,
  output logic        irqReq
);

  localparam int CNT_W = $clog2(EXEC_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EXEC_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic gMask;
  logic cmdMask;
  logic doneFlag;
  logic clrDone;
  logic unusedBits;

  assign strb.accept   = cmdWrEn && !busy;
  assign strb.complete = busy && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (strb.accept) begin
      busy <= 1'b1;
      cnt  <= CNT_LOAD;
    end else if (busy) begin
      cnt <= cnt - CNT_LAST;
      if (strb.complete) busy <= 1'b0;
    end
  end

  assign clrDone = intWrEn && intWrData[16];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gMask    <= 1'b1;
      cmdMask  <= 1'b1;
      doneFlag <= 1'b0;
    end else begin
      if (intWrEn) begin
        gMask   <= intWrData[0];
        cmdMask <= intWrData[2];
      end
      // a completion in the same cycle as a clear wins
      doneFlag <= strb.complete || (doneFlag && !clrDone);
    end
  end

  assign intCtlWord = {15'b0, doneFlag, 13'b0, cmdMask, 1'b0, gMask};
  assign irqReq     = doneFlag && !gMask && !cmdMask;
  assign unusedBits = ^{intWrData[31:17], intWrData[15:3], intWrData[1]};

endmodule

// File: rtl/hpcmd_dpath.sv
module hpcmd_dpath
  import hpcmd_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  hpStrobe_t              strb,
  input  hpAction_t              decAct,
  input  logic [NUM_SLOTS-1:0]   mrlOpen,
  output logic [2:0]             errCode,
  output logic [3:0]             busMode,
  output logic [2*NUM_SLOTS-1:0] slotState,
  output logic [2*NUM_SLOTS-1:0] pwrInd,
  output logic [2*NUM_SLOTS-1:0] attnInd
);

  hpAction_t            pend;
  logic [NUM_SLOTS-1:0] pendMrl;
  hpErr_t               errR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend    <= '0;
      pendMrl <= '0;
      errR    <= ERR_NONE;
      busMode <= 4'd0;
    end else if (strb.accept) begin
      pend    <= decAct;
      pendMrl <= mrlOpen;
      errR    <= ERR_NONE;
    end else if (strb.complete) begin
      errR <= pend.err;
      if (pend.modeOp) busMode <= pend.modeVal;
    end
  end

  assign errCode = errR;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [1:0] stR;
    logic [1:0] pwrR;
    logic [1:0] attnR;
    logic       hit;

    assign hit = pend.slotOp && (pend.slotNum == 8'(s + 1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stR   <= ST_DISABLED;
        pwrR  <= IND_OFF;
        attnR <= IND_OFF;
      end else if (strb.complete) begin
        if (hit) begin
          if (pend.stFld   != 2'd0) stR   <= pend.stFld;
          if (pend.pwrFld  != 2'd0) pwrR  <= pend.pwrFld;
          if (pend.attnFld != 2'd0) attnR <= pend.attnFld;
        end else if (pend.allOp && !pendMrl[s]) begin
          stR <= pend.allState;
        end
      end
    end

    assign slotState[2*s +: 2] = stR;
    assign pwrInd[2*s +: 2]    = pwrR;
    assign attnInd[2*s +: 2]   = attnR;
  end

endmodule

// File: rtl/hpcmd_exec.sv
module hpcmd_exec
  import hpcmd_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int EXEC_CYCLES = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdWrEn,
  input  logic [15:0]            cmdWord,
  input  logic [7:0]             progIf,
  input  logic [NUM_SLOTS-1:0]   mrlOpen,
  input  logic                   intWrEn,
  input  logic [31:0]            intWrData,
  output logic [15:0]            statusWord,
  output logic [31:0]            intCtlWord,
  output logic                   irqReq,
  output logic [2*NUM_SLOTS-1:0] slotState,
  output logic [2*NUM_SLOTS-1:0] pwrInd,
  output logic [2*NUM_SLOTS-1:0] attnInd,
  output logic [3:0]             busMode
);

  hpStrobe_t  strb;
  hpAction_t  decAct;
  logic       busy;
  logic [2:0] errCode;

  hpcmd_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
    .cmdWord (cmdWord),
    .progIf  (progIf),
    .mrlOpen (mrlOpen),
    .act     (decAct)
  );

  hpcmd_ctrl #(.EXEC_CYCLES(EXEC_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWrEn    (cmdWrEn),
    .intWrEn    (intWrEn),
    .intWrData  (intWrData),
    .strb       (strb),
    .busy       (busy),
    .intCtlWord (intCtlWord),
    .irqReq     (irqReq)
  );

  hpcmd_dpath #(.NUM_SLOTS(NUM_SLOTS)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .decAct    (decAct),
    .mrlOpen   (mrlOpen),
    .errCode   (errCode),
    .busMode   (busMode),
    .slotState (slotState),
    .pwrInd    (pwrInd),
    .attnInd   (attnInd)
  );

  assign statusWord = {12'b0, errCode, busy};

endmodule

// File: rtl/hpcmd_exec_chk.sv
module hpcmd_exec_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cmdWrEn,
  input logic                   complete,
  input logic [15:0]            statusWord,
  input logic [31:0]            intCtlWord,
  input logic [2*NUM_SLOTS-1:0] slotState,
  input logic [2*NUM_SLOTS-1:0] pwrInd,
  input logic [2*NUM_SLOTS-1:0] attnInd,
  input logic [3:0]             busMode
);

  // R2
  busy_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[0]) |-> $past(cmdWrEn));

  // R10
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[0] && !complete) |=> (statusWord[0] && $stable(statusWord[3:1])));

  // R13
  err_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(statusWord[3:1]));

  // R9
  outputs_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !complete |=> ($stable(slotState) && $stable(pwrInd) && $stable(attnInd) && $stable(busMode)));

  // R11
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusWord[0]) |-> intCtlWord[16]);

  // R11
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intCtlWord[16]) |-> $past(statusWord[0]));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_fld
    // R3
    field_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (slotState[2*s +: 2] != 2'd0) && (pwrInd[2*s +: 2] != 2'd0) && (attnInd[2*s +: 2] != 2'd0));
  end

endmodule

bind hpcmd_exec hpcmd_exec_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdWrEn    (cmdWrEn),
  .complete   (strb.complete),
  .statusWord (statusWord),
  .intCtlWord (intCtlWord),
  .slotState  (slotState),
  .pwrInd     (pwrInd),
  .attnInd    (attnInd),
  .busMode    (busMode)
);

// File: tb/hpcmd_exec_bench.sv
module hpcmd_exec_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int EXEC = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdWrEn = 1'b0;
  logic [15:0]   cmdWord = '0;
  logic [7:0]    progIf = 8'd1;
  logic [NS-1:0] mrlOpen = '0;
  logic          intWrEn = 1'b0;
  logic [31:0]   intWrData = '0;
  logic [15:0]   statusWord;
  logic [31:0]   intCtlWord;
  logic          irqReq;
  logic [2*NS-1:0] slotState;
  logic [2*NS-1:0] pwrInd;
  logic [2*NS-1:0] attnInd;
  logic [3:0]    busMode;

  int testCnt = 0;
  int failCnt = 0;

  logic [1:0] eSt [NS];
  logic [1:0] ePwr [NS];
  logic [1:0] eAttn [NS];
  logic [3:0] eMode;
  logic       gM;
  logic       cM;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpcmd_exec #(.NUM_SLOTS(NS), .EXEC_CYCLES(EXEC)) u_hpcmd_exec (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWrEn    (cmdWrEn),
    .cmdWord    (cmdWord),
    .progIf     (progIf),
    .mrlOpen    (mrlOpen),
    .intWrEn    (intWrEn),
    .intWrData  (intWrData),
    .statusWord (statusWord),
    .intCtlWord (intCtlWord),
    .irqReq     (irqReq),
    .slotState  (slotState),
    .pwrInd     (pwrInd),
    .attnInd    (attnInd),
    .busMode    (busMode)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // reference model of one command; returns expected one-hot error
  task automatic modelCmd(input logic [15:0] w, input logic [NS-1:0] mrl,
                          input logic [7:0] pi, output logic [2:0] err);
    logic [7:0] c;
    int sn;
    c = w[7:0];
    sn = int'(w[15:8]);
    err = 3'b000;
    if (c inside {[8'h00:8'h3F]}) begin
      if (sn < 1 || sn > NS) err = 3'b010;
      else if (mrl[sn-1] && c[1:0] != 2'd0) err = 3'b001;
      else begin
        if (c[1:0] != 0) eSt[sn-1] = c[1:0];
        if (c[3:2] != 0) ePwr[sn-1] = c[3:2];
        if (c[5:4] != 0) eAttn[sn-1] = c[5:4];
      end
    end else if (c inside {[8'h40:8'h44]}) eMode = {1'b0, c[2:0]};
    else if (c inside {[8'h45:8'h47], [8'h5E:8'h5F]}) err = 3'b100;
    else if (c == 8'h48 || c == 8'h49) begin
      for (int s = 0; s < NS; s++) if (!mrl[s]) eSt[s] = (c == 8'h48) ? 2'd1 : 2'd2;
    end else if (c inside {[8'h50:8'h5D]}) begin
      if (pi == 8'd2) eMode = c[3:0];
      else err = 3'b100;
    end else err = 3'b010;
  endtask

  task automatic checkOutputs(input string req);
    logic [2*NS-1:0] xs, xp, xa;
    for (int s = 0; s < NS; s++) begin
      xs[2*s +: 2] = eSt[s];
      xp[2*s +: 2] = ePwr[s];
      xa[2*s +: 2] = eAttn[s];
    end
    check(slotState == xs, req, "slotState", 32'(slotState), 32'(xs));
    check(pwrInd == xp, req, "pwrInd", 32'(pwrInd), 32'(xp));
    check(attnInd == xa, req, "attnInd", 32'(attnInd), 32'(xa));
    check(busMode == eMode, req, "busMode", 32'(busMode), 32'(eMode));
  endtask

  // write masks and optionally clear the done flag; checks afterwards
  task automatic writeInt(input logic g, input logic cm, input logic clr);
    logic expDone;
    expDone = intCtlWord[16] && !clr;
    @(negedge clk);
    intWrEn = 1'b1;
    intWrData = {15'b0, clr, 13'b0, cm, 1'b0, g};
    @(negedge clk);
    intWrEn = 1'b0;
    gM = g;
    cM = cm;
    check(intCtlWord[16] == expDone, "R11", "done after clear", 32'(intCtlWord[16]), 32'(expDone));
    check(irqReq == (expDone && !g && !cm), "R12", "irqReq", 32'(irqReq),
          32'(expDone && !g && !cm));
  endtask

  // issue a command; optionally intrude with another write during busy cycle
  // intrudeAt, and/or clear the done flag in the last busy cycle
  task automatic doCmd(input logic [15:0] w, input logic [NS-1:0] mrl,
                       input logic [7:0] pi, input string req,
                       input int intrudeAt, input logic [15:0] intrudeWord,
                       input bit clrAtEnd);
    logic [2:0] expErr;
    int n;
    @(negedge clk);
    mrlOpen = mrl;
    progIf = pi;
    cmdWord = w;
    cmdWrEn = 1'b1;
    modelCmd(w, mrl, pi, expErr);
    @(negedge clk);
    cmdWrEn = 1'b0;
    n = 0;
    while (statusWord[0] && n < 1000) begin
      n++;
      if (n == 1)
        check(statusWord[3:1] == 3'b000, "R13", "err cleared at accept",
              32'(statusWord[3:1]), 32'd0);
      if (n == intrudeAt) begin
        cmdWord = intrudeWord;
        cmdWrEn = 1'b1;
      end
      if (clrAtEnd && n == EXEC) begin
        intWrEn = 1'b1;
        intWrData = {15'b0, 1'b1, 13'b0, cM, 1'b0, gM};
      end
      @(negedge clk);
      cmdWrEn = 1'b0;
      intWrEn = 1'b0;
    end
    check(n == EXEC, "R2", "busy cycles", 32'(n), 32'(EXEC));
    check(statusWord[3:1] == expErr, req, "error code", 32'(statusWord[3:1]), 32'(expErr));
    check(intCtlWord[16] == 1'b1, "R11", "done flag set", 32'(intCtlWord[16]), 32'd1);
    check(irqReq == (!gM && !cM), "R12", "irqReq after completion", 32'(irqReq), 32'(!gM && !cM));
    checkOutputs(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < NS; s++) begin
      eSt[s] = 2'd3;
      ePwr[s] = 2'd3;
      eAttn[s] = 2'd3;
    end
    eMode = 4'd0;
    gM = 1'b1;
    cM = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(statusWord == 16'h0, "R1", "status", 32'(statusWord), 32'h0);
    check(intCtlWord == 32'h5, "R1", "intCtlWord", intCtlWord, 32'h5);
    check(irqReq == 1'b0, "R1", "irqReq", 32'(irqReq), 32'h0);
    checkOutputs("R1");

    writeInt(1'b0, 1'b0, 1'b1);

    // R3 slot operations, zero fields keep values
    doCmd({8'd1, 8'h3A}, '0, 8'd1, "R3", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    doCmd({8'd2, 8'h01}, '0, 8'd1, "R3", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    doCmd({8'd2, 8'h24}, '0, 8'd1, "R3", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    // R4 bad slot numbers
    doCmd({8'd0, 8'h02}, '0, 8'd1, "R4", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    doCmd({8'(NS + 1), 8'h02}, '0, 8'd1, "R4", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    // R5 MRL open
    doCmd({8'd3, 8'h03}, 4'b0100, 8'd1, "R5", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    doCmd({8'd3, 8'h10}, 4'b0100, 8'd1, "R5", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    // R6 base modes
    doCmd(16'h0043, '0, 8'd1, "R6", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    doCmd(16'h0046, '0, 8'd1, "R6", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    // R7 all-slot commands
    doCmd(16'h0048, 4'b0001, 8'd1, "R7", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    doCmd(16'h0049, 4'b1000, 8'd1, "R7", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    // R8 extended modes
    doCmd(16'h0057, '0, 8'd2, "R8", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    doCmd(16'h005A, '0, 8'd1, "R8", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    doCmd(16'h005F, '0, 8'd2, "R8", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    // R9 reserved and vendor codes
    doCmd(16'h004C, '0, 8'd2, "R9", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    doCmd(16'h01C5, '0, 8'd2, "R9", 0, '0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    // R10 writes while busy, mid-period and on the last busy cycle
    doCmd({8'd4, 8'h2A}, '0, 8'd1, "R10", 3, 16'h00C0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    doCmd({8'd4, 8'h01}, '0, 8'd1, "R10", EXEC, {8'd4, 8'h03}, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);
    // R11 clear in the completion cycle: set wins (flag set beforehand too)
    doCmd(16'h0041, '0, 8'd1, "R11", 0, '0, 1'b0);
    doCmd(16'h0042, '0, 8'd1, "R11", 0, '0, 1'b1);
    // R12 masks
    writeInt(1'b1, 1'b0, 1'b0);
    writeInt(1'b0, 1'b1, 1'b0);
    writeInt(1'b0, 1'b0, 1'b0);
    writeInt(1'b0, 1'b0, 1'b1);

    // random commands
    for (int k = 0; k < 150; k++) begin
      logic [7:0] c;
      logic [7:0] sn;
      int cat;
      cat = int'($urandom % 6);
      sn = 8'($urandom % (NS + 2));
      case (cat)
        0, 1, 2: c = 8'($urandom % 64);
        3: c = 8'(8'h40 + $urandom % 10);
        4: c = 8'(8'h50 + $urandom % 16);
        default: c = 8'($urandom);
      endcase
      doCmd({sn, c}, NS'($urandom), (($urandom % 2) != 0) ? 8'd2 : 8'd1, "R3", 0, '0,
            (($urandom % 4) == 0));
      writeInt(1'($urandom), 1'($urandom), 1'b1);
    end

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule